// File: doc/BRIEF.md
# Flash Sector Write-Guard

This block keeps the write-protection state of a 4 MB flash array made of 64 sectors of 64 KB each. A command decoder in front of it sends single-cycle requests to protect or unprotect one sector, to protect or unprotect every sector at once, or to lock down one sector for good. Lockdown is modelled as a register that only power-on reset clears. An active-low hardware write-protect input freezes the sectors that are already protected. Commands may still add protection while it is low.

Before a program or erase starts, the decoder sends the start address and the operation size. One cycle later the block reports whether the operation may go ahead. A rejected operation sets a sticky error flag, and the flag stays set until software reads it. The protection and lockdown bits of any sector can be read back at any time through a combinational sector-select port.

Top module: `sp_guard`

## Requirements
- R1: After reset every sector reads as unprotected and unlocked. `err_flag` and `chk_done` are 0, and a full-chip erase check is allowed.
- R2: The sector index is address bits 21:16. A protect command (`cmd_op`=1) marks only that sector protected, and `stat_prot` then reads 1 for it.
- R3: An unprotect command (`cmd_op`=2) clears the protection of the addressed sector, as long as `wp_n` is 1 and the sector is not locked down.
- R4: A global protect command (`cmd_op`=3) protects all 64 sectors. A global unprotect command (`cmd_op`=4) clears protection on every sector that is not locked down, as long as `wp_n` is 1.
- R5: A lockdown command (`cmd_op`=5) sets the sector's `stat_lock`. No later command clears it, and a locked sector always reads `stat_prot`=1, even after a global unprotect.
- R6: While `wp_n` is 0, unprotect and global unprotect have no effect on protected sectors. Protect, global protect and lockdown still take effect.
- R7: For a program check (`chk_kind`=0) or a 4 KB, 32 KB or 64 KB erase check (`chk_kind`=1, 2, 3), `chk_allow` is 1 exactly when the 64 KB sector holding `chk_addr` is neither protected nor locked. The result appears with `chk_done`=1 one cycle after `chk_valid`.
- R8: A full-chip erase check (`chk_kind` 4 to 7) is allowed only when no sector is protected or locked.
- R9: A rejected check sets `err_flag` one cycle later. The flag stays set until a cycle with `err_rd`=1, after which it reads 0. If a rejection and a read arrive in the same cycle, the flag stays set.
- R10: A check made in the same cycle as a command is judged against the protection state from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wp_n | input | 1 | Hardware write protect, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 none, 1 protect, 2 unprotect, 3 protect all, 4 unprotect all, 5 lockdown, 6-7 none |
| cmd_addr | input | 22 | Byte address naming the sector for a command |
| chk_valid | input | 1 | Operation check strobe |
| chk_kind | input | 3 | 0 program, 1 erase 4 KB, 2 erase 32 KB, 3 erase 64 KB, 4-7 full chip |
| chk_addr | input | 22 | Start address of the checked operation |
| err_rd | input | 1 | Read of the error flag; clears it |
| stat_sel | input | 6 | Sector whose status is shown |
| chk_done | output | 1 | Check result valid |
| chk_allow | output | 1 | Checked operation is permitted |
| err_flag | output | 1 | Sticky rejection flag |
| stat_prot | output | 1 | Selected sector is protected (includes lockdown) |
| stat_lock | output | 1 | Selected sector is locked down |

## Verification
The assertions assume that only power-on reset clears lockdown. They also assume that `wp_n` is sampled on the same edge as the command it gates, so a command arriving while the pin is low can never lower any sector's protection. The bench drives every input at the falling clock edge and holds it through the next rising edge, so each command and check is seen on exactly one edge. The random phase keeps lockdown commands rare, so that most sectors stay open and allowed operations are still exercised.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROT   = 3'd1,
    OP_UNPROT = 3'd2,
    OP_ALLP   = 3'd3,
    OP_ALLU   = 3'd4,
    OP_LOCK   = 3'd5
  } op_e;

  localparam logic [2:0] KIND_PROG  = 3'd0;
  localparam logic [2:0] KIND_CHIP  = 3'd4;
endpackage

// File: rtl/sp_state.sv
module sp_state #(
  parameter int NUM_SECTORS = 64,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wp_n,
  input  sp_pkg::op_e            op,
  input  logic [SEC_W-1:0]       sec,
  output logic [NUM_SECTORS-1:0] prot_q,
  output logic [NUM_SECTORS-1:0] lock_q,
  output logic [NUM_SECTORS-1:0] eff
);
  import sp_pkg::*;

  assign eff = prot_q | lock_q;

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sec
    logic hit;
    logic clr_ok;
    assign hit    = (sec == SEC_W'(g));
    assign clr_ok = wp_n && !lock_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prot_q[g] <= 1'b0;
        lock_q[g] <= 1'b0;
      end else begin
        case (op)
          OP_PROT:   if (hit) prot_q[g] <= 1'b1;
          OP_UNPROT: if (hit && clr_ok) prot_q[g] <= 1'b0;
          OP_ALLP:   prot_q[g] <= 1'b1;
          OP_ALLU:   if (clr_ok) prot_q[g] <= 1'b0;
          OP_LOCK:   if (hit) lock_q[g] <= 1'b1;
          default:   ;
        endcase
      end
    end
  end

  // lockdown bits only ever rise (R5)
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // with the pin low, nothing protected becomes unprotected (R6)
  p_wp_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> ((eff & $past(eff)) == $past(eff)));
endmodule

// File: rtl/sp_check.sv
module sp_check #(
  parameter int NUM_SECTORS = 64,
  localparam int SEC_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SECTORS-1:0] eff,
  input  logic                   chk_valid,
  input  logic [2:0]             chk_kind,
  input  logic [SEC_W-1:0]       chk_sec,
  input  logic                   err_rd,
  output logic                   allow_now,
  output logic                   chk_done,
  output logic                   chk_allow,
  output logic                   err_flag
);
  import sp_pkg::*;

  function automatic logic op_allowed(input logic [NUM_SECTORS-1:0] st,
                                      input logic [2:0] kind,
                                      input logic [SEC_W-1:0] s);
    if (kind >= KIND_CHIP) return ~|st;
    return ~st[s];
  endfunction

  logic reject;
  assign allow_now = op_allowed(eff, chk_kind, chk_sec);
  assign reject    = chk_valid && !allow_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_done  <= 1'b0;
      chk_allow <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      chk_done  <= chk_valid;
      chk_allow <= chk_valid && allow_now;
      if (reject)      err_flag <= 1'b1;
      else if (err_rd) err_flag <= 1'b0;
    end
  end

  p_reject_sets_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !allow_now) |=> err_flag);

  p_chip_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_kind >= KIND_CHIP && (|eff)) |=> (chk_done && !chk_allow));
endmodule

// File: rtl/sp_guard.sv
module sp_guard #(
  parameter int NUM_SECTORS  = 64,
  parameter int SECTOR_BYTES = 65536,
  localparam int SEC_W    = $clog2(NUM_SECTORS),
  localparam int SECT_LSB = $clog2(SECTOR_BYTES),
  localparam int ADDR_W   = SECT_LSB + SEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              chk_valid,
  input  logic [2:0]        chk_kind,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              err_rd,
  input  logic [SEC_W-1:0]  stat_sel,
  output logic              chk_done,
  output logic              chk_allow,
  output logic              err_flag,
  output logic              stat_prot,
  output logic              stat_lock
);
  import sp_pkg::*;

  function automatic logic [SEC_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SECT_LSB];
  endfunction

  logic [NUM_SECTORS-1:0] prot_q, lock_q, eff;
  logic                   allow_now;
  op_e                    op_eff;
  logic                   unused_lo;

  assign op_eff    = cmd_valid ? op_e'(cmd_op) : OP_NONE;
  assign unused_lo = ^{cmd_addr[SECT_LSB-1:0], chk_addr[SECT_LSB-1:0], prot_q};

  sp_state #(.NUM_SECTORS(NUM_SECTORS)) u_state (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op(op_eff),
    .sec(sector_of(cmd_addr)), .prot_q(prot_q), .lock_q(lock_q), .eff(eff)
  );

  sp_check #(.NUM_SECTORS(NUM_SECTORS)) u_check (
    .clk(clk), .rst_n(rst_n), .eff(eff), .chk_valid(chk_valid),
    .chk_kind(chk_kind), .chk_sec(sector_of(chk_addr)), .err_rd(err_rd),
    .allow_now(allow_now), .chk_done(chk_done), .chk_allow(chk_allow),
    .err_flag(err_flag)
  );

  assign stat_prot = eff[stat_sel];
  assign stat_lock = lock_q[stat_sel];

  p_lock_reads_prot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_lock |-> stat_prot);

  // a check result follows every strobe, one cycle later (R7)
  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);

  p_allow_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && allow_now) |=> chk_allow);
endmodule

// File: tb/tb_sp_guard.sv
`timescale 1ns/1ps
module tb_sp_guard;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, wp_n = 1'b1, cmd_valid = 1'b0, chk_valid = 1'b0, err_rd = 1'b0;
  logic [2:0] cmd_op = '0, chk_kind = '0;
  logic [21:0] cmd_addr = '0, chk_addr = '0;
  logic [5:0] stat_sel = '0;
  logic chk_done, chk_allow, err_flag, stat_prot, stat_lock;

  sp_guard dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  string scen = "R1";
  bit [63:0] m_prot = '0, m_lock = '0;
  bit m_done = 0, m_allow = 0, m_err = 0;

  function automatic bit m_ok(int kind, int sec);
    if (kind >= 4) return (m_prot | m_lock) == 64'd0;
    return !(m_prot[sec] || m_lock[sec]);
  endfunction

  task automatic check(logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL [%s] %s actual=%0b expected=%0b t=%0t", scen, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int s;
    bit ok;
    if (!rst_n) begin
      m_prot = '0; m_lock = '0; m_done = 0; m_allow = 0; m_err = 0;
      return;
    end
    ok = m_ok(int'(chk_kind), int'(chk_addr[21:16]));
    m_done  = chk_valid;
    m_allow = chk_valid && ok;
    if (chk_valid && !ok) m_err = 1;
    else if (err_rd) m_err = 0;
    s = int'(cmd_addr[21:16]);
    if (cmd_valid) begin
      case (cmd_op)
        3'd1: m_prot[s] = 1;
        3'd2: if (wp_n && !m_lock[s]) m_prot[s] = 0;
        3'd3: m_prot = '1;
        3'd4: if (wp_n) m_prot = m_prot & m_lock;
        3'd5: m_lock[s] = 1;
        default: ;
      endcase
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(chk_done, m_done, "R7 chk_done");
    check(chk_allow, m_allow, "R7/R8 chk_allow");
    check(err_flag, m_err, "R9 err_flag");
    check(stat_prot, m_prot[stat_sel] | m_lock[stat_sel], "R2 stat_prot");
    check(stat_lock, m_lock[stat_sel], "R5 stat_lock");
  endtask

  task automatic do_cmd(int op, int sec);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = {6'(sec), 16'(sec * 97)};
    cyc();
    cmd_valid = 0;
  endtask

  task automatic do_chk(int kind, int sec, bit exp, string tag);
    chk_valid = 1; chk_kind = 3'(kind); chk_addr = {6'(sec), 16'hA5C3};
    cyc();
    chk_valid = 0;
    check(chk_allow, exp, tag);
  endtask

  task automatic look(int sec, bit ep, bit el, string tag);
    stat_sel = 6'(sec);
    cyc();
    check(stat_prot, ep, {tag, " prot"});
    check(stat_lock, el, {tag, " lock"});
  endtask

  task automatic rd_err();
    err_rd = 1; cyc(); err_rd = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    scen = "R1";
    check(err_flag, 1'b0, "R1 err after reset");
    for (int i = 0; i < 64; i++) look(i, 0, 0, "R1 sector");
    do_chk(4, 0, 1, "R1 chip erase after reset");

    scen = "R2";
    do_cmd(1, 5);
    look(5, 1, 0, "R2 sector 5");
    look(6, 0, 0, "R2 sector 6");
    do_chk(0, 5, 0, "R2 program protected");
    check(err_flag, 1'b1, "R9 err set");
    do_chk(3, 6, 1, "R7 64K erase open");
    rd_err();
    check(err_flag, 1'b0, "R9 err cleared");

    scen = "R3";
    do_cmd(2, 5);
    do_chk(1, 5, 1, "R3 4K erase after unprotect");

    scen = "R4";
    do_cmd(3, 0);
    do_chk(2, 40, 0, "R4 32K erase after global protect");
    do_chk(4, 0, 0, "R8 chip after global protect");
    do_cmd(4, 0);
    do_chk(4, 0, 1, "R4 chip after global unprotect");
    rd_err();

    scen = "R5";
    do_cmd(5, 63);
    do_cmd(2, 63);
    do_cmd(4, 0);
    look(63, 1, 1, "R5 sector 63");
    do_chk(0, 63, 0, "R5 program locked");
    do_chk(4, 1, 0, "R8 chip with lock");
    do_chk(0, 62, 1, "R7 program neighbour");

    scen = "R6";
    do_cmd(1, 10);
    wp_n = 0;
    do_cmd(2, 10);
    do_cmd(4, 0);
    look(10, 1, 0, "R6 sector 10 held");
    do_cmd(1, 11);
    look(11, 1, 0, "R6 protect under wp");
    do_cmd(5, 12);
    look(12, 1, 1, "R6 lock under wp");
    wp_n = 1;
    do_cmd(4, 0);
    look(10, 0, 0, "R4 sector 10 cleared");
    look(12, 1, 1, "R5 sector 12 kept");

    scen = "R10";
    chk_valid = 1; chk_kind = 0; chk_addr = {6'd20, 16'h0};
    cmd_valid = 1; cmd_op = 3'd1; cmd_addr = {6'd20, 16'h0};
    cyc();
    chk_valid = 0; cmd_valid = 0;
    check(chk_allow, 1'b1, "R10 check uses old state");
    do_chk(0, 20, 0, "R10 next check sees protect");

    scen = "R9";
    chk_valid = 1; chk_kind = 0; chk_addr = {6'd20, 16'h0}; err_rd = 1;
    cyc();
    chk_valid = 0; err_rd = 0;
    check(err_flag, 1'b1, "R9 set wins over read");
    rd_err();
    check(err_flag, 1'b0, "R9 read clears");

    scen = "R7";
    for (int i = 0; i < 500; i++) begin
      wp_n      = ($urandom % 4) != 0;
      cmd_valid = $urandom % 2;
      cmd_op    = 3'($urandom);
      if (cmd_op == 3'd5 && ($urandom % 8) != 0) cmd_op = 3'd2;
      cmd_addr  = 22'($urandom);
      chk_valid = $urandom % 2;
      chk_kind  = 3'($urandom);
      chk_addr  = 22'($urandom);
      err_rd    = ($urandom % 3) == 0;
      stat_sel  = 6'($urandom);
      cyc();
    end
    cmd_valid = 0; chk_valid = 0; err_rd = 0;
    cyc();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule